// File: doc/BRIEF.md
# Key-Gated Banked Configuration Register Space

This block is the configuration front end of a multi-function peripheral controller, sitting as a slave on an 8-bit I/O bus. It decodes exactly two bus addresses: a base port (`BASE_PORT`, either 0x3F0 or 0x370) and a data port one above it. Out of reset the block is in run mode and the data port behaves like an empty bus location. Software unlocks the space by writing a fixed key byte twice in a row to the base port. It closes the space again with a different key byte.

While the space is unlocked, a byte written to the base port becomes the register index. The data port then reads or writes the register at that index. A few indices are global and shared by every function. The others are banked: a logical-device-number register picks one of nine register sets, so one index/data pair reaches all nine functions. The banks drive the enable, I/O base address, interrupt and DMA settings consumed by the function blocks around it. Three banks carry extra registers: the keyboard bank, the floppy bank and the parallel bank.

Reads are combinational. Writes take effect on the rising clock edge of the bus cycle that carries them.

Top module: `kcfg_space`

## Requirements
- R1: After reset the block is in run mode (`cfg_mode`=0), the logical device number is 0, and every banked register is zero, so all devices are disabled and every base, interrupt and DMA output is zero.
- R2: Two consecutive base-port writes of 0x55 put the block in configuration mode; `cfg_mode` goes high after the second write.
- R3: A base-port write of any value other than 0x55 after a single 0x55 cancels the partial unlock, so a later 0x55 counts as the first key again.
- R4: In configuration mode a base-port write of 0xAA returns the block to run mode. In run mode, data-port reads return 0xFF and data-port writes change no register.
- R5: In configuration mode any other base-port write sets the index. The index stays unchanged across data-port accesses and across leaving and re-entering configuration mode.
- R6: Index 0x07 is the logical device number, readable and writable. Values 0 to 8 select the floppy(0), IDE1(1), IDE2(2), parallel(3), serial 1(4), serial 2(5), clock(6), keyboard(7) and auxiliary(8) banks, and each bank holds its own values.
- R7: Index 0x20 reads the device ID 0x02 and index 0x21 reads the revision 0x01. Writes to either index are ignored.
- R8: Banked index 0x30 is the activate register. Its bit 0 drives `dev_enable[n]` for bank n, and a read returns 0x00 or 0x01.
- R9: Banked indices 0x60 and 0x61 hold the high and low bytes of the device I/O base, which appears on `dev_base[16n+15:16n]`.
- R10: Banked index 0x70 is the primary interrupt for every bank. Index 0x72 exists only in the keyboard bank and index 0x74 only in the floppy and parallel banks. In any other bank these indices read 0x00 and ignore writes.
- R11: The floppy bank has read/write registers at 0x90 (mode) and 0x91 (option). `fdc_burst` is high when bits 3:1 of the mode register are all set.
- R12: Global index 0x22 reads {2'b00, dev_enable[5:0]}, so bit n is the enable of device n. Writes to it are ignored.
- R13: Unimplemented indices read 0x00 and ignore writes. A logical device number above 8 selects no bank, so banked reads return 0x00 and banked writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0xFF when not driving configuration data |
| cfg_mode | output | 1 | High while the configuration space is unlocked |
| dev_enable | output | NUM_DEV | Per-device activate bit |
| dev_base | output | 16*NUM_DEV | Per-device I/O base, 16 bits per device |
| dev_irq | output | 8*NUM_DEV | Per-device primary interrupt select |
| kbd_irq2 | output | 8 | Keyboard secondary interrupt select |
| fdc_dma | output | 8 | Floppy DMA channel select |
| par_dma | output | 8 | Parallel DMA channel select |
| fdc_mode | output | 8 | Floppy mode register |
| fdc_option | output | 8 | Floppy option register |
| fdc_burst | output | 1 | Floppy burst enable |

## Verification
The assertions check on every cycle the rules that can be stated between neighbouring cycles:
- configuration mode only begins after a 0x55 base-port write;
- the close key always exits;
- the index never moves outside configuration mode;
- at most one bank accepts a write;
- a bank's enable and base hold unless that bank is written;
- run-mode data writes leave the enables untouched;
- the power-control read mirrors the enable outputs.

Only the bench scenarios can show the following:
- the exact key sequences, including a broken unlock;
- the separation of the nine banks;
- that optional registers are absent from the other banks;
- that an out-of-range device number drops writes;
- that index and bank state survive a lock and unlock cycle.

// File: rtl/kcfg_pkg.sv
package kcfg_pkg;
   localparam logic [7:0] KEY_OPEN   = 8'h55;
   localparam logic [7:0] KEY_CLOSE  = 8'hAA;

   localparam logic [7:0] IX_LDN     = 8'h07;
   localparam logic [7:0] IX_ID      = 8'h20;
   localparam logic [7:0] IX_REV     = 8'h21;
   localparam logic [7:0] IX_PWR     = 8'h22;
   localparam logic [7:0] IX_ACT     = 8'h30;
   localparam logic [7:0] IX_BASE_HI = 8'h60;
   localparam logic [7:0] IX_BASE_LO = 8'h61;
   localparam logic [7:0] IX_IRQ     = 8'h70;
   localparam logic [7:0] IX_IRQ2    = 8'h72;
   localparam logic [7:0] IX_DMA     = 8'h74;
   localparam logic [7:0] IX_FMODE   = 8'h90;
   localparam logic [7:0] IX_FOPT    = 8'h91;

   typedef enum logic [1:0] {
      KS_RUN  = 2'd0,
      KS_HALF = 2'd1,
      KS_CFG  = 2'd2
   } key_state_e;
endpackage

// File: rtl/kcfg_key_fsm.sv
module kcfg_key_fsm
   import kcfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       base_wr,
   input  logic [7:0] wdata,
   output logic       cfg_mode,
   output logic [7:0] idx
);
   key_state_e st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= KS_RUN;
         idx  <= '0;
      end else if (base_wr) begin
         case (st_q)
            KS_RUN:  if (wdata == KEY_OPEN) st_q <= KS_HALF;
            KS_HALF: st_q <= (wdata == KEY_OPEN) ? KS_CFG : KS_RUN;
            KS_CFG: begin
               if (wdata == KEY_CLOSE) st_q <= KS_RUN;
               else                    idx  <= wdata;
            end
            default: st_q <= KS_RUN;
         endcase
      end
   end

   assign cfg_mode = (st_q == KS_CFG);

   // R2: configuration mode is only ever entered on an open-key write
   p_enter_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_mode) |-> $past(base_wr && wdata == KEY_OPEN));

   // R4: the close key always leaves configuration mode
   p_close_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode && base_wr && wdata == KEY_CLOSE) |=> !cfg_mode);

   // R5: the index is frozen outside configuration mode
   p_idx_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mode |=> $stable(idx));
endmodule

// File: rtl/kcfg_bank.sv
module kcfg_bank
   import kcfg_pkg::*;
#(
   parameter bit HAS_IRQ2 = 1'b0,
   parameter bit HAS_DMA  = 1'b0,
   parameter bit HAS_FDC  = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [7:0]  idx,
   input  logic [7:0]  wdata,
   output logic        active,
   output logic [15:0] base,
   output logic [7:0]  irq,
   output logic [7:0]  irq2,
   output logic [7:0]  dma,
   output logic [7:0]  fmode,
   output logic [7:0]  fopt,
   output logic [7:0]  rdata
);
   logic       act_q;
   logic [7:0] hi_q, lo_q, irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         hi_q  <= '0;
         lo_q  <= '0;
         irq_q <= '0;
      end else if (wr_en) begin
         case (idx)
            IX_ACT:     act_q <= wdata[0];
            IX_BASE_HI: hi_q  <= wdata;
            IX_BASE_LO: lo_q  <= wdata;
            IX_IRQ:     irq_q <= wdata;
            default: ;
         endcase
      end
   end

   if (HAS_IRQ2) begin : g_irq2
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                       q <= '0;
         else if (wr_en && idx == IX_IRQ2) q <= wdata;
      end
      assign irq2 = q;
   end else begin : g_no_irq2
      assign irq2 = '0;
   end

   if (HAS_DMA) begin : g_dma
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                      q <= '0;
         else if (wr_en && idx == IX_DMA) q <= wdata;
      end
      assign dma = q;
   end else begin : g_no_dma
      assign dma = '0;
   end

   if (HAS_FDC) begin : g_fdc
      logic [7:0] mode_q, opt_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mode_q <= '0;
            opt_q  <= '0;
         end else if (wr_en) begin
            if (idx == IX_FMODE) mode_q <= wdata;
            if (idx == IX_FOPT)  opt_q  <= wdata;
         end
      end
      assign fmode = mode_q;
      assign fopt  = opt_q;
   end else begin : g_no_fdc
      assign fmode = '0;
      assign fopt  = '0;
   end

   assign active = act_q;
   assign base   = {hi_q, lo_q};
   assign irq    = irq_q;

   always_comb begin
      case (idx)
         IX_ACT:     rdata = {7'b0, act_q};
         IX_BASE_HI: rdata = hi_q;
         IX_BASE_LO: rdata = lo_q;
         IX_IRQ:     rdata = irq_q;
         IX_IRQ2:    rdata = irq2;
         IX_DMA:     rdata = dma;
         IX_FMODE:   rdata = fmode;
         IX_FOPT:    rdata = fopt;
         default:    rdata = 8'h00;
      endcase
   end

   // R8: enable only moves on a write into this bank
   p_act_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(active));

   // R9: base address only moves on a write into this bank
   p_base_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(base));
endmodule

// File: rtl/kcfg_space.sv
module kcfg_space
   import kcfg_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          BASE_PORT = 16'h3F0,
   parameter int          NUM_DEV   = 9,
   parameter int          FDC_DEV   = 0,
   parameter int          PAR_DEV   = 3,
   parameter int          KBD_DEV   = 7,
   parameter logic [7:0]  DEV_ID    = 8'h02,
   parameter logic [7:0]  DEV_REV   = 8'h01
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       io_addr,
   input  logic                    io_wr,
   input  logic                    io_rd,
   input  logic [7:0]              io_wdata,
   output logic [7:0]              io_rdata,
   output logic                    cfg_mode,
   output logic [NUM_DEV-1:0]      dev_enable,
   output logic [16*NUM_DEV-1:0]   dev_base,
   output logic [8*NUM_DEV-1:0]    dev_irq,
   output logic [7:0]              kbd_irq2,
   output logic [7:0]              fdc_dma,
   output logic [7:0]              par_dma,
   output logic [7:0]              fdc_mode,
   output logic [7:0]              fdc_option,
   output logic                    fdc_burst
);
   localparam int PWR_BITS  = 6;
   localparam int DATA_PORT = BASE_PORT + 1;

   if (BASE_PORT != 16'h3F0 && BASE_PORT != 16'h370) begin : g_chk_base
      $error("kcfg_space: BASE_PORT must be 0x3F0 or 0x370");
   end
   if (ADDR_W < 10) begin : g_chk_addr
      $error("kcfg_space: ADDR_W too narrow for the port");
   end
   if (NUM_DEV < PWR_BITS || NUM_DEV > 16) begin : g_chk_ndev
      $error("kcfg_space: NUM_DEV out of range");
   end
   if (FDC_DEV >= NUM_DEV || PAR_DEV >= NUM_DEV || KBD_DEV >= NUM_DEV) begin : g_chk_roles
      $error("kcfg_space: special bank number beyond NUM_DEV");
   end

   logic       base_hit, data_hit, base_wr, data_wr;
   logic [7:0] idx, ldn_q, sel_rd, cfg_rd, pwr_val;
   logic [NUM_DEV-1:0] bank_wr;
   logic [7:0] bank_rd   [NUM_DEV];
   logic [7:0] bank_irq2 [NUM_DEV];
   logic [7:0] bank_dma  [NUM_DEV];
   logic [7:0] bank_fm   [NUM_DEV];
   logic [7:0] bank_fo   [NUM_DEV];

   assign base_hit = (io_addr == ADDR_W'(BASE_PORT));
   assign data_hit = (io_addr == ADDR_W'(DATA_PORT));
   assign base_wr  = io_wr && base_hit;
   assign data_wr  = io_wr && data_hit && cfg_mode;

   kcfg_key_fsm u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .base_wr  (base_wr),
      .wdata    (io_wdata),
      .cfg_mode (cfg_mode),
      .idx      (idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                         ldn_q <= '0;
      else if (data_wr && idx == IX_LDN)  ldn_q <= io_wdata;
   end

   for (genvar n = 0; n < NUM_DEV; n++) begin : g_bank
      assign bank_wr[n] = data_wr && (ldn_q == 8'(n));
      kcfg_bank #(
         .HAS_IRQ2 (n == KBD_DEV),
         .HAS_DMA  (n == FDC_DEV || n == PAR_DEV),
         .HAS_FDC  (n == FDC_DEV)
      ) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (bank_wr[n]),
         .idx    (idx),
         .wdata  (io_wdata),
         .active (dev_enable[n]),
         .base   (dev_base[16*n +: 16]),
         .irq    (dev_irq[8*n +: 8]),
         .irq2   (bank_irq2[n]),
         .dma    (bank_dma[n]),
         .fmode  (bank_fm[n]),
         .fopt   (bank_fo[n]),
         .rdata  (bank_rd[n])
      );
   end

   assign kbd_irq2   = bank_irq2[KBD_DEV];
   assign fdc_dma    = bank_dma[FDC_DEV];
   assign par_dma    = bank_dma[PAR_DEV];
   assign fdc_mode   = bank_fm[FDC_DEV];
   assign fdc_option = bank_fo[FDC_DEV];
   assign fdc_burst  = &fdc_mode[3:1];
   assign pwr_val    = 8'(dev_enable[PWR_BITS-1:0]);

   always_comb begin
      sel_rd = 8'h00;
      for (int n = 0; n < NUM_DEV; n++)
         if (ldn_q == 8'(n)) sel_rd = bank_rd[n];
      case (idx)
         IX_LDN:  cfg_rd = ldn_q;
         IX_ID:   cfg_rd = DEV_ID;
         IX_REV:  cfg_rd = DEV_REV;
         IX_PWR:  cfg_rd = pwr_val;
         default: cfg_rd = sel_rd;
      endcase
   end

   assign io_rdata = (io_rd && data_hit && cfg_mode) ? cfg_rd : 8'hFF;

   // R6: a data write lands in at most one bank
   p_one_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_wr));

   // R4: run-mode data writes leave every enable untouched
   p_run_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_mode && io_wr && data_hit) |=> $stable(dev_enable));

   // R12: power-control read mirrors the low enable outputs
   p_pwr_view_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode && io_rd && data_hit && idx == IX_PWR)
         |-> io_rdata == {2'b00, dev_enable[PWR_BITS-1:0]});
endmodule

// File: tb/kcfg_space_tb.sv
module kcfg_space_tb;
   localparam int NV = 63;
   localparam logic [15:0] BP = 16'h3F0;
   localparam logic [1:0] WB = 2'd0, WD = 2'd1, RD = 2'd2;

   // {requirement, op, data, expected}
   localparam logic [21:0] VEC [NV] = '{
      {4'd2, WB, 8'h55, 8'h00}, {4'd2, WB, 8'h55, 8'h00},
      {4'd7, WB, 8'h20, 8'h00}, {4'd7, RD, 8'h00, 8'h02},   // R7 id
      {4'd7, WB, 8'h21, 8'h00}, {4'd7, RD, 8'h00, 8'h01},   // R7 rev
      {4'd6, WB, 8'h07, 8'h00}, {4'd6, WD, 8'h04, 8'h00},
      {4'd6, RD, 8'h00, 8'h04},                             // R6 ldn readback
      {4'd9, WB, 8'h60, 8'h00}, {4'd9, WD, 8'h03, 8'h00},
      {4'd9, WB, 8'h61, 8'h00}, {4'd9, WD, 8'hF8, 8'h00},
      {4'd10, WB, 8'h70, 8'h00}, {4'd10, WD, 8'h04, 8'h00},
      {4'd8, WB, 8'h30, 8'h00}, {4'd8, WD, 8'hFF, 8'h00},
      {4'd8, RD, 8'h00, 8'h01},                             // R8 bit 0 only
      {4'd9, WB, 8'h60, 8'h00}, {4'd9, RD, 8'h00, 8'h03},
      {4'd9, WB, 8'h61, 8'h00}, {4'd9, RD, 8'h00, 8'hF8},
      {4'd10, WB, 8'h72, 8'h00}, {4'd10, WD, 8'h09, 8'h00},
      {4'd10, RD, 8'h00, 8'h00},                            // R10 no irq2 in serial
      {4'd10, WB, 8'h74, 8'h00}, {4'd10, WD, 8'h02, 8'h00},
      {4'd10, RD, 8'h00, 8'h00},                            // R10 no dma in serial
      {4'd12, WB, 8'h22, 8'h00}, {4'd12, RD, 8'h00, 8'h10}, // R12
      {4'd6, WB, 8'h07, 8'h00}, {4'd6, WD, 8'h07, 8'h00},
      {4'd10, WB, 8'h72, 8'h00}, {4'd10, WD, 8'h0C, 8'h00},
      {4'd10, RD, 8'h00, 8'h0C},                            // R10 keyboard irq2
      {4'd10, WB, 8'h70, 8'h00}, {4'd10, WD, 8'h01, 8'h00},
      {4'd6, WB, 8'h07, 8'h00}, {4'd6, WD, 8'h00, 8'h00},
      {4'd11, WB, 8'h90, 8'h00}, {4'd11, WD, 8'h0E, 8'h00},
      {4'd11, RD, 8'h00, 8'h0E},                            // R11 mode
      {4'd11, WB, 8'h91, 8'h00}, {4'd11, WD, 8'h5A, 8'h00},
      {4'd11, RD, 8'h00, 8'h5A},                            // R11 option
      {4'd10, WB, 8'h74, 8'h00}, {4'd10, WD, 8'h02, 8'h00},
      {4'd10, RD, 8'h00, 8'h02},                            // R10 floppy dma
      {4'd6, WB, 8'h07, 8'h00}, {4'd6, WD, 8'h04, 8'h00},
      {4'd6, WB, 8'h70, 8'h00}, {4'd6, RD, 8'h00, 8'h04},   // R6 bank kept
      {4'd13, WB, 8'h07, 8'h00}, {4'd13, WD, 8'h0A, 8'h00},
      {4'd13, WB, 8'h70, 8'h00}, {4'd13, WD, 8'h05, 8'h00},
      {4'd13, RD, 8'h00, 8'h00},                            // R13 no bank
      {4'd13, WB, 8'h07, 8'h00}, {4'd13, WD, 8'h04, 8'h00},
      {4'd13, WB, 8'h70, 8'h00}, {4'd13, RD, 8'h00, 8'h04}, // R13 write dropped
      {4'd13, WB, 8'h50, 8'h00}, {4'd13, RD, 8'h00, 8'h00}  // R13 unimplemented
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        cfg_mode;
   logic [8:0]  dev_enable;
   logic [143:0] dev_base;
   logic [71:0] dev_irq;
   logic [7:0]  kbd_irq2, fdc_dma, par_dma, fdc_mode, fdc_option;
   logic        fdc_burst;
   int total = 0, bad = 0;

   always #4 clk = ~clk;

   kcfg_space u_dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_mode(cfg_mode),
      .dev_enable(dev_enable), .dev_base(dev_base), .dev_irq(dev_irq),
      .kbd_irq2(kbd_irq2), .fdc_dma(fdc_dma), .par_dma(par_dma),
      .fdc_mode(fdc_mode), .fdc_option(fdc_option), .fdc_burst(fdc_burst)
   );

   task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input bit data_port, input logic [7:0] v);
      @(negedge clk);
      io_addr = data_port ? BP + 16'd1 : BP;
      io_wdata = v;
      io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input string req, input logic [7:0] exp);
      @(negedge clk);
      io_addr = BP + 16'd1;
      io_rd = 1'b1;
      #1;
      chk(req, 160'(io_rdata), 160'(exp));
      io_rd = 1'b0;
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 cfg_mode", 160'(cfg_mode), 160'(0));
      chk("R1 enables", 160'(dev_enable), 160'(0));
      chk("R1 bases", 160'(dev_base), 160'(0));
      chk("R1 irqs", 160'(dev_irq), 160'(0));
      rst_n = 1'b1;
      rd("R4 run read", 8'hFF);

      for (int i = 0; i < NV; i++) begin
         case (VEC[i][17:16])
            WB: wr(1'b0, VEC[i][15:8]);
            WD: wr(1'b1, VEC[i][15:8]);
            default: rd($sformatf("R%0d vec%0d", VEC[i][21:18], i), VEC[i][7:0]);
         endcase
      end

      // R12 / R7 writes ignored
      wr(1'b0, 8'h22); wr(1'b1, 8'hFF); rd("R12 write ignored", 8'h10);
      wr(1'b0, 8'h20); wr(1'b1, 8'h77); rd("R7 write ignored", 8'h02);
      // R5 index persists over reads
      wr(1'b0, 8'h61); rd("R5 first read", 8'hF8); rd("R5 second read", 8'hF8);

      // output checks
      chk("R2 cfg_mode", 160'(cfg_mode), 160'(1));
      chk("R8 dev_enable", 160'(dev_enable), 160'(9'h010));
      chk("R9 dev_base", 160'(dev_base[64 +: 16]), 160'(16'h03F8));
      chk("R10 serial irq", 160'(dev_irq[32 +: 8]), 160'(8'h04));
      chk("R10 kbd irq", 160'(dev_irq[56 +: 8]), 160'(8'h01));
      chk("R10 kbd irq2", 160'(kbd_irq2), 160'(8'h0C));
      chk("R10 fdc dma", 160'(fdc_dma), 160'(8'h02));
      chk("R10 par dma", 160'(par_dma), 160'(8'h00));
      chk("R11 fdc mode", 160'(fdc_mode), 160'(8'h0E));
      chk("R11 fdc option", 160'(fdc_option), 160'(8'h5A));
      chk("R11 burst on", 160'(fdc_burst), 160'(1));

      // R11 partial burst bits
      wr(1'b0, 8'h07); wr(1'b1, 8'h00); wr(1'b0, 8'h90); wr(1'b1, 8'h06);
      chk("R11 burst off", 160'(fdc_burst), 160'(0));
      wr(1'b0, 8'h07); wr(1'b1, 8'h04); wr(1'b0, 8'h70);

      // R4 lock, run-mode access, R5 index kept across unlock
      wr(1'b0, 8'hAA);
      chk("R4 locked", 160'(cfg_mode), 160'(0));
      rd("R4 locked read", 8'hFF);
      wr(1'b1, 8'h09);
      wr(1'b0, 8'h55); wr(1'b0, 8'h55);
      chk("R2 reopened", 160'(cfg_mode), 160'(1));
      rd("R4 run write ignored", 8'h04);

      // R3 broken unlock
      wr(1'b0, 8'hAA); wr(1'b0, 8'h55); wr(1'b0, 8'h12); wr(1'b0, 8'h55);
      chk("R3 broken key", 160'(cfg_mode), 160'(0));
      wr(1'b0, 8'h55);
      chk("R3 restarted key", 160'(cfg_mode), 160'(1));
      rd("R5 index after relock", 8'h04);

      // R1 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      chk("R1 reset cfg", 160'(cfg_mode), 160'(0));
      chk("R1 reset enables", 160'(dev_enable), 160'(0));
      chk("R1 reset kbd irq2", 160'(kbd_irq2), 160'(0));
      wr(1'b0, 8'h55); wr(1'b0, 8'h55);
      wr(1'b0, 8'h07); rd("R1 ldn zero", 8'h00);
      wr(1'b0, 8'h90); rd("R1 fdc mode zero", 8'h00);
      finish_run();
   end
endmodule